// File: doc/BRIEF.md
# Status byte service request generator

This block builds the eight-bit status byte of a test instrument and raises a service request toward the bus controller. It holds a sticky standard event register, which is set by event pulses and emptied by a clear-status strobe. It also takes in a live extended event vector with its enable mask, plus flags saying that the error queue or the output queue holds data. Each of these sources is reduced to one summary bit. A writable enable register then chooses which summary bits may contribute to the master summary.

Bit 6 of the byte has two meanings, and the read path selects which one is returned. A status-query read returns the live master summary and leaves all state as it was. A serial-poll read returns the request-service latch and then clears it. That latch sets when the master summary rises. It clears after a serial poll or when the master summary falls, and it drives the service-request output directly. Each read returns its byte one clock after the strobe, together with a valid flag.

Top module: `status_srq`

## Requirements
- R1: Bits 7, 3 and 0 of every returned byte are 0.
- R2: Bit 1 is 1 when any bit of the extended event input ANDed with its enable input is 1.
- R3: Bit 2 equals the error-queue non-empty flag, and bit 4 equals the output-queue non-empty flag.
- R4: A pulse on a standard event input sets the matching bit of the standard event register, and that bit stays set. Bit 5 is 1 when any standard register bit ANDed with its enable input is 1, starting from the clock after the pulse.
- R5: A clear-status strobe empties the standard event register on the next clock, so bit 5 falls and bit 4 is unchanged. An event pulse in the same cycle as the strobe is kept.
- R6: A status-query read returns the master summary in bit 6. The master summary is the OR of (bits 5, 4, 2, 1 AND the matching enable bits). The read clears nothing, so repeated queries return the same byte.
- R7: A write to the service request enable register takes effect on the next clock. Bit 6 of the written value is ignored and always reads back as 0.
- R8: The request latch sets on the clock after the master summary goes from 0 to 1. The service-request output equals the latch.
- R9: A serial-poll read returns the request latch in bit 6 and all other bits as a status query would, then clears the latch. If both read strobes are high, the serial poll is served.
- R10: The request latch clears on the clock after the master summary falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std_evt_i | input | STD_W | Standard event pulses, one per register bit |
| std_en_i | input | STD_W | Standard event enable mask |
| ext_evt_i | input | EXT_W | Extended event register contents |
| ext_en_i | input | EXT_W | Extended event enable mask |
| err_nempty_i | input | 1 | Error queue holds data |
| out_nempty_i | input | 1 | Output queue holds data |
| sre_we_i | input | 1 | Service request enable write strobe |
| sre_wdata_i | input | 8 | Service request enable write value |
| cls_i | input | 1 | Clear-status strobe |
| stq_rd_i | input | 1 | Status-query read strobe |
| spoll_rd_i | input | 1 | Serial-poll read strobe |
| sre_o | output | 8 | Current service request enable register |
| rd_valid_o | output | 1 | Returned byte valid, one clock after a read strobe |
| rd_data_o | output | 8 | Returned status byte |
| srq_o | output | 1 | Service request, equal to the request latch |

## Verification
The bench builds the block with four standard event bits and three extended event bits. With these widths, a short table of vectors can set or mask every extended bit and reach every combination of source and enable. Directed sequences cover the cases that depend on order: a poll that clears the latch while the summary stays high, a repeated query, clear-status against an event in the same cycle, the latch falling with the summary, and the ignored enable bit 6.

// File: rtl/status_srq.sv
module status_srq #(
  parameter int STD_W = 8,
  parameter int EXT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STD_W-1:0] std_evt_i,
  input  logic [STD_W-1:0] std_en_i,
  input  logic [EXT_W-1:0] ext_evt_i,
  input  logic [EXT_W-1:0] ext_en_i,
  input  logic             err_nempty_i,
  input  logic             out_nempty_i,
  input  logic             sre_we_i,
  input  logic [7:0]       sre_wdata_i,
  input  logic             cls_i,
  input  logic             stq_rd_i,
  input  logic             spoll_rd_i,
  output logic [7:0]       sre_o,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  output logic             srq_o
);
  localparam logic [7:0] SRE_MASK = 8'hBF;

  logic [STD_W-1:0] std_q;
  logic [7:0]       sre_q;
  logic             mss_d, rqs_q;

  logic ees, esb, mss, mss_rise;
  logic [7:0] low_byte;

  assign ees      = |(ext_evt_i & ext_en_i);
  assign esb      = |(std_q & std_en_i);
  assign low_byte = {2'b00, esb, out_nempty_i, 1'b0, err_nempty_i, ees, 1'b0};
  assign mss      = |(low_byte & sre_q);
  assign mss_rise = mss & ~mss_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      std_q      <= '0;
      sre_q      <= '0;
      mss_d      <= 1'b0;
      rqs_q      <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      std_q <= (cls_i ? '0 : std_q) | std_evt_i;
      if (sre_we_i) sre_q <= sre_wdata_i & SRE_MASK;
      mss_d <= mss;
      rqs_q <= mss & (mss_rise | (rqs_q & ~spoll_rd_i));
      rd_valid_o <= stq_rd_i | spoll_rd_i;
      if (spoll_rd_i)    rd_data_o <= low_byte | {1'b0, rqs_q, 6'b0};
      else if (stq_rd_i) rd_data_o <= low_byte | {1'b0, mss, 6'b0};
    end
  end

  assign sre_o = sre_q;
  assign srq_o = rqs_q;

  a_r1_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (rd_data_o[7] == 1'b0 && rd_data_o[3] == 1'b0 && rd_data_o[0] == 1'b0));

  always_comb a_r7_bit6_zero: assert (sre_q[6] == 1'b0);

  a_r5_cls_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i && std_evt_i == '0) |=> std_q == '0);

  a_r8_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mss && !mss_d) |=> srq_o);

  a_r9_poll_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (spoll_rd_i && !(mss && !mss_d)) |=> !srq_o);

  a_r10_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !mss |=> !srq_o);
endmodule

// File: tb/status_srq_test.sv
module status_srq_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 4;
  localparam int EW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SW-1:0] std_evt = '0, std_en = '0;
  logic [EW-1:0] ext_evt = '0, ext_en = '0;
  logic err_ne = 1'b0, out_ne = 1'b0, sre_we = 1'b0, cls = 1'b0, stq = 1'b0, spoll = 1'b0;
  logic [7:0] sre_wdata = '0;
  logic [7:0] sre, rd_data;
  logic rd_valid, srq;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_srq #(.STD_W(SW), .EXT_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .std_evt_i(std_evt), .std_en_i(std_en),
    .ext_evt_i(ext_evt), .ext_en_i(ext_en), .err_nempty_i(err_ne), .out_nempty_i(out_ne),
    .sre_we_i(sre_we), .sre_wdata_i(sre_wdata), .cls_i(cls), .stq_rd_i(stq),
    .spoll_rd_i(spoll), .sre_o(sre), .rd_valid_o(rd_valid), .rd_data_o(rd_data), .srq_o(srq));

  // {ext_evt, ext_en, err, out, sre, expected query byte}
  localparam logic [23:0] VEC [6] = '{
    {3'b101, 3'b100, 1'b0, 1'b0, 8'h00, 8'h02},
    {3'b011, 3'b100, 1'b1, 1'b0, 8'h04, 8'h44},
    {3'b010, 3'b010, 1'b0, 1'b1, 8'h02, 8'h52},
    {3'b000, 3'b111, 1'b1, 1'b1, 8'h10, 8'h54},
    {3'b111, 3'b111, 1'b1, 1'b1, 8'hA9, 8'h16},
    {3'b001, 3'b000, 1'b0, 1'b0, 8'hFF, 8'h00}
  };

  task automatic tick(); @(negedge clk); endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_sre(logic [7:0] v);
    sre_wdata = v; sre_we = 1'b1; tick(); sre_we = 1'b0;
  endtask

  task automatic query(output logic [7:0] d);
    stq = 1'b1; tick(); stq = 1'b0; d = rd_data;
    check("R1 valid", {7'b0, rd_valid}, 8'h01);
  endtask

  task automatic poll(output logic [7:0] d);
    spoll = 1'b1; tick(); spoll = 1'b0; d = rd_data;
  endtask

  task automatic pulse_evt(logic [SW-1:0] b, logic with_cls);
    std_evt = b; cls = with_cls; tick(); std_evt = '0; cls = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    tick(); tick(); rst_n = 1'b1; tick();
    check("reset rd_data", rd_data, 8'h00);
    check("reset srq", {7'b0, srq}, 8'h00);
    check("reset sre", sre, 8'h00);
    check("reset rd_valid", {7'b0, rd_valid}, 8'h00);

    foreach (VEC[i]) begin
      write_sre(VEC[i][15:8]);
      ext_evt = VEC[i][23:21]; ext_en = VEC[i][20:18];
      err_ne = VEC[i][17]; out_ne = VEC[i][16];
      tick();
      check("R7 sre readback bit6 ignored", sre, VEC[i][15:8] & 8'hBF);
      query(d);
      check("R1 R2 R3 R6 query byte", d, VEC[i][7:0]);
    end

    ext_evt = '0; ext_en = '0; err_ne = 1'b0; out_ne = 1'b1;
    write_sre(8'h20); std_en = 4'b0010; tick();
    check("R8 srq idle", {7'b0, srq}, 8'h00);
    pulse_evt(4'b0010, 1'b0);
    check("R8 srq not yet", {7'b0, srq}, 8'h00);
    tick();
    check("R8 srq set after rise", {7'b0, srq}, 8'h01);
    tick(); tick();
    query(d); check("R4 sticky event bit5 mss", d, 8'h70);
    query(d); check("R6 query clears nothing", d, 8'h70);
    check("R6 srq after query", {7'b0, srq}, 8'h01);
    poll(d); check("R9 poll returns latch", d, 8'h70);
    check("R9 srq cleared by poll", {7'b0, srq}, 8'h00);
    poll(d); check("R9 second poll latch 0", d, 8'h30);
    query(d); check("R6 mss still live", d, 8'h70);
    stq = 1'b1; spoll = 1'b1; tick(); stq = 1'b0; spoll = 1'b0;
    check("R9 both strobes serve poll", rd_data, 8'h30);

    cls = 1'b1; tick(); cls = 1'b0;
    query(d); check("R5 cls drops bit5 keeps bit4", d, 8'h10);
    pulse_evt(4'b0001, 1'b0);
    query(d); check("R4 disabled event bit masked", d, 8'h10);
    cls = 1'b1; tick(); cls = 1'b0;
    pulse_evt(4'b0010, 1'b1);
    query(d); check("R5 event wins over cls", d, 8'h70);
    check("R8 srq set again", {7'b0, srq}, 8'h01);
    std_en = 4'b0000; tick();
    check("R10 srq clears on mss fall", {7'b0, srq}, 8'h00);
    std_en = 4'b0010; tick(); tick();
    check("R8 srq resets on new rise", {7'b0, srq}, 8'h01);
    write_sre(8'h00); tick();
    check("R10 masking drops srq", {7'b0, srq}, 8'h00);

    cls = 1'b1; tick(); cls = 1'b0;
    out_ne = 1'b0; err_ne = 1'b1; write_sre(8'h44);
    check("R7 sre write bit6 ignored", sre, 8'h04);
    tick();
    check("R8 error source raises srq", {7'b0, srq}, 8'h01);
    poll(d); check("R1 R3 poll byte", d, 8'h44);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule